// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked system read and write a 32K x 8 asynchronous static RAM, one word at a time. A request arrives on a valid/ready handshake carrying a direction bit, a 15-bit address and a write byte. The controller turns it into active-low chip select, write enable and output enable strobes and drives the address and the data bus. The data bus is split into an output, a driver enable and an input, so the pad can be built outside the block.

Every strobe phase lasts a whole number of clock cycles. These counts are worked out at elaboration from the clock period and from the memory's minimum intervals, given in nanoseconds. The intervals are the write pulse width, the data setup before the write-ending edge, the recovery gap and full write cycle, the address and output-enable access times, and the time the memory needs to release the bus. A read returns its byte with a one-cycle valid pulse. When a read is followed directly by another read, chip select and output enable stay low and only the address moves. When a read is followed by a write, a turnaround gap keeps the two sides from driving the bus at once.

Top module: `sram_async_ctrl`

## Requirements
- R1: While rst_ni is low, and from the moment it falls, sram_cs_no, sram_we_no and sram_oe_no are high, sram_dq_oe_o and rd_valid_o are low, and after reset req_ready_o is high.
- R2: An accepted write holds sram_cs_no and sram_we_no low together for exactly WP_CYC = ceil(max(45 ns, 35 ns) / clock period) cycles (9 at a 5 ns clock), starting in the cycle after acceptance. sram_oe_no stays high and sram_addr_o stays constant for the whole pulse.
- R3: sram_dq_oe_o is high in every cycle where sram_we_no is low and is never high while sram_oe_no is low. The write byte is constant on sram_dq_o for at least 35 ns before sram_we_no rises.
- R4: After sram_we_no rises it stays high for at least REC_CYC cycles. REC_CYC is at least 1, covers 5 ns, and makes the whole write cycle at least 50 ns. sram_cs_no rises with it, so a control line toggles between writes.
- R5: A read drives sram_cs_no and sram_oe_no low with sram_we_no high. It samples sram_dq_i RD_CYC = ceil(max(50 ns, 15 ns) / clock period) cycles after the address and output enable change (10 at a 5 ns clock). It then presents the byte on rd_data_o with rd_valid_o high.
- R6: A read request present in the cycle where rd_valid_o is high is accepted then. sram_cs_no and sram_oe_no stay low across both reads, and only sram_addr_o changes.
- R7: After a read, sram_cs_no and sram_oe_no are high for at least TA_CYC = max(1, ceil(15 ns / clock period)) cycles (3 at a 5 ns clock) before sram_dq_oe_o can rise.
- R8: req_ready_o is low in the cycle after every accepted request. A request held valid while the block is busy is performed exactly once.
- R9: rd_valid_o is high for single cycles only, and only for accepted reads, never for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (15) | Word address |
| req_wdata_i | input | DATA_W (8) | Write byte |
| rd_valid_o | output | 1 | One-cycle pulse with read result |
| rd_data_o | output | DATA_W (8) | Read byte |
| sram_addr_o | output | ADDR_W (15) | Memory address |
| sram_cs_no | output | 1 | Chip select, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_dq_o | output | DATA_W (8) | Data driven toward memory |
| sram_dq_oe_o | output | 1 | Data driver enable |
| sram_dq_i | input | DATA_W (8) | Data returned by memory |

## Verification
Returning a read result and accepting the next request happen in the same cycle, because the block is ready while rd_valid_o is high. The bench provokes this by queuing requests back to back, so the next request is already valid when a read completes. Some of these follow-ups are reads and some are writes. The scoreboard checks each returned byte against its own shadow memory. A memory model that tracks strobe history judges what follows: the chained read must leave chip select low, and the write must wait out the bus release time before driving.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_HOLD,
    ST_TURN,
    ST_WR,
    ST_WR_REC
  } seq_state_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned WP_CYC  = 5,
  parameter int unsigned REC_CYC = 1,
  parameter int unsigned RD_CYC  = 5,
  parameter int unsigned TA_CYC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             tmr_done_i,
  output logic             req_ready_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             cs_n_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             dq_oe_o
);

  localparam logic [CNT_W-1:0] WP_V  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_V = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] RD_V  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TA_V  = CNT_W'(TA_CYC - 1);

  seq_state_e state_q, state_d;
  logic       pend_wr_q, pend_wr_d;
  logic       cs_n_q, we_n_q, oe_n_q, dq_oe_q;

  assign req_ready_o = (state_q == ST_IDLE) || (state_q == ST_RD_HOLD);
  assign accept_o    = req_valid_i && req_ready_o;
  assign capture_o   = (state_q == ST_RD) && tmr_done_i;

  always_comb begin
    state_d    = state_q;
    pend_wr_d  = pend_wr_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          tmr_load_o = 1'b1;
          if (req_write_i) begin
            state_d   = ST_WR;
            tmr_val_o = WP_V;
          end else begin
            state_d   = ST_RD;
            tmr_val_o = RD_V;
          end
        end
      end
      ST_RD: begin
        if (tmr_done_i) state_d = ST_RD_HOLD;
      end
      ST_RD_HOLD: begin
        tmr_load_o = 1'b1;
        if (req_valid_i && !req_write_i) begin
          // chained read: strobes stay low, only address moves
          state_d   = ST_RD;
          tmr_val_o = RD_V;
        end else begin
          // release bus; a write waits out the turnaround
          state_d   = ST_TURN;
          tmr_val_o = TA_V;
          pend_wr_d = req_valid_i;
        end
      end
      ST_TURN: begin
        if (tmr_done_i) begin
          if (pend_wr_q) begin
            state_d    = ST_WR;
            tmr_load_o = 1'b1;
            tmr_val_o  = WP_V;
            pend_wr_d  = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_WR: begin
        if (tmr_done_i) begin
          state_d    = ST_WR_REC;
          tmr_load_o = 1'b1;
          tmr_val_o  = REC_V;
        end
      end
      ST_WR_REC: begin
        if (tmr_done_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes registered from next state: no decode glitches at the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pend_wr_q <= 1'b0;
      cs_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      dq_oe_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      pend_wr_q <= pend_wr_d;
      cs_n_q    <= !((state_d == ST_RD) || (state_d == ST_RD_HOLD) || (state_d == ST_WR));
      we_n_q    <= (state_d != ST_WR);
      oe_n_q    <= !((state_d == ST_RD) || (state_d == ST_RD_HOLD));
      dq_oe_q   <= (state_d == ST_WR) || (state_d == ST_WR_REC);
    end
  end

  assign cs_n_o  = cs_n_q;
  assign we_n_o  = we_n_q;
  assign oe_n_o  = oe_n_q;
  assign dq_oe_o = dq_oe_q;

endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rvld_q <= capture_i;
      if (capture_i) rdata_q <= dq_i;
    end
  end

  assign addr_o     = addr_q;
  assign dq_o       = wdata_q;
  assign rd_valid_o = rvld_q;
  assign rd_data_o  = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_WP_NS       = 45,  // write pulse / select to end of write
  parameter int unsigned T_DS_NS       = 35,  // data setup to write end
  parameter int unsigned T_WR_NS       = 5,   // write recovery high time
  parameter int unsigned T_WC_NS       = 50,  // full write cycle
  parameter int unsigned T_AA_NS       = 50,  // address access
  parameter int unsigned T_OE_NS       = 15,  // output-enable access
  parameter int unsigned T_HZ_NS       = 15   // memory bus release
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_cs_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned P        = CLK_PERIOD_NS;
  localparam int unsigned WP_CYC   = max_u(1, max_u(ceil_div(T_WP_NS, P), ceil_div(T_DS_NS, P)));
  localparam int unsigned WC_CYC   = ceil_div(T_WC_NS, P);
  localparam int unsigned WC_REM   = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 0;
  localparam int unsigned REC_CYC  = max_u(1, max_u(ceil_div(T_WR_NS, P), WC_REM));
  localparam int unsigned RD_CYC   = max_u(1, max_u(ceil_div(T_AA_NS, P), ceil_div(T_OE_NS, P)));
  localparam int unsigned TA_CYC   = max_u(1, ceil_div(T_HZ_NS, P));
  localparam int unsigned MAX_CYC  = max_u(max_u(WP_CYC, REC_CYC), max_u(RD_CYC, TA_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC) + 1;

  logic             accept, capture, tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  sram_seq_fsm #(
    .CNT_W   (CNT_W),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .RD_CYC  (RD_CYC),
    .TA_CYC  (TA_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .tmr_done_i  (tmr_done),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .capture_o   (capture),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .cs_n_o      (sram_cs_no),
    .we_n_o      (sram_we_no),
    .oe_n_o      (sram_oe_no),
    .dq_oe_o     (sram_dq_oe_o)
  );

  sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .addr_i     (req_addr_i),
    .wdata_i    (req_wdata_i),
    .capture_i  (capture),
    .dq_i       (sram_dq_i),
    .addr_o     (sram_addr_o),
    .dq_o       (sram_dq_o),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_write_i,
  input logic              rd_valid_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic              sram_cs_no,
  input logic              sram_we_no,
  input logic              sram_oe_no,
  input logic              sram_dq_oe_o
);

  p_we_needs_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (!sram_cs_no && sram_oe_no));

  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && $past(!sram_we_no)) |-> $stable(sram_addr_o));

  p_drive_in_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_dq_oe_o);

  p_no_drive_on_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);

  p_recovery_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (sram_cs_no ##1 sram_we_no));

  p_chain_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && req_valid_i && req_ready_o && !req_write_i) |=> (!sram_cs_no && !sram_oe_no));

  p_turnaround_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> ($past(sram_oe_no) && $past(sram_cs_no)));

  p_busy_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_write_i  (req_write_i),
  .rd_valid_o   (rd_valid_o),
  .sram_addr_o  (sram_addr_o),
  .sram_cs_no   (sram_cs_no),
  .sram_we_no   (sram_we_no),
  .sram_oe_no   (sram_oe_no),
  .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

  // expected phase lengths at a 5 ns clock, from the requirement formulas
  localparam int WP_E  = 9;   // ceil(45/5)
  localparam int DS_E  = 7;   // ceil(35/5)
  localparam int REC_E = 1;
  localparam int RD_E  = 10;  // ceil(50/5)
  localparam int TA_E  = 3;   // ceil(15/5)

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready_o, rd_valid_o;
  logic [7:0]  rd_data_o;
  logic [14:0] sram_addr_o;
  logic        sram_cs_no, sram_we_no, sram_oe_no, sram_dq_oe_o;
  logic [7:0]  sram_dq_o;
  logic [7:0]  sram_dq_i = '0;

  always #2.5 clk = ~clk;

  sram_async_ctrl #(.CLK_PERIOD_NS(5)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .sram_addr_o(sram_addr_o), .sram_cs_no(sram_cs_no), .sram_we_no(sram_we_no),
    .sram_oe_no(sram_oe_no), .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o),
    .sram_dq_i(sram_dq_i)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  // memory model + scoreboard state
  logic [7:0] mem     [int];
  logic [7:0] exp_mem [int];
  logic [7:0] q[$];
  int  n_wr = 0, wr_count = 0;
  int  wlen = 0, dlen = 0, whigh = 0, age = 0, drv_cnt = 0;
  int  cs_rise = 0, last_pop_cs_rise = 0;
  bit  wr_prev = 0, rd_prev = 0, cs_prev = 1, rdv_prev = 0;
  logic [14:0] wr_addr = '0, rd_addr = '0;
  logic [7:0]  wdat = '0;

  function automatic logic [7:0] mrd(input logic [14:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (!rst_ni) begin
      wr_prev = 0; rd_prev = 0; cs_prev = 1; rdv_prev = 0;
      wlen = 0; dlen = 0; whigh = 0; age = 0; drv_cnt = 0;
    end else begin
      bit rd_act, wr_act;
      rd_act = !sram_cs_no && !sram_oe_no && sram_we_no;
      wr_act = !sram_cs_no && !sram_we_no;
      // R7: drivers never overlap the memory's output or its release window
      if (sram_dq_oe_o) chk(!rd_act && drv_cnt == 0, "R7 bus contention", drv_cnt, 0);
      // R3: driver follows the write pulse, never with output enable low
      if (!sram_we_no) chk(sram_dq_oe_o, "R3 driver in pulse", sram_dq_oe_o, 1);
      if (sram_dq_oe_o) chk(sram_oe_no, "R3 no drive while oe low", sram_oe_no, 1);
      if (wr_act) begin
        if (!wr_prev) begin
          if (wr_count > 0) chk(whigh >= REC_E, "R4 recovery", whigh, REC_E);
          chk(sram_oe_no, "R2 oe high during write", sram_oe_no, 1);
          wlen = 0; dlen = 0;
        end else
          chk(sram_addr_o == wr_addr, "R2 address stable", sram_addr_o, wr_addr);
        wlen++;
        if (sram_dq_oe_o && wr_prev && sram_dq_o == wdat) dlen++;
        else dlen = sram_dq_oe_o ? 1 : 0;
        wdat = sram_dq_o; wr_addr = sram_addr_o;
        whigh = 0;
      end else begin
        if (wr_prev) begin
          chk(wlen == WP_E, "R2 write pulse length", wlen, WP_E);
          chk(dlen >= DS_E, "R3 data setup", dlen, DS_E);
          chk(sram_cs_no, "R4 cs toggles after write", sram_cs_no, 1);
          mem[int'(wr_addr)] = wdat;
          wr_count++;
        end
        if (sram_we_no) whigh++;
      end
      // read access age: cycles since address / output enable change
      if (rd_act && rd_prev && sram_addr_o == rd_addr) age++;
      else age = 0;
      rd_addr = sram_addr_o;
      sram_dq_i = (rd_act && age >= RD_E - 1) ? mrd(sram_addr_o) : ~mrd(sram_addr_o);
      if (rd_act) drv_cnt = TA_E;
      else if (drv_cnt > 0) drv_cnt--;
      if (sram_cs_no && !cs_prev) cs_rise++;
      cs_prev = sram_cs_no; wr_prev = wr_act; rd_prev = rd_act;
      // scoreboard monitor
      if (rd_valid_o) begin
        chk(!rdv_prev, "R9 single-cycle rd_valid", rdv_prev, 0);
        if (q.size() == 0) chk(0, "R9 rd_valid without read", 1, 0);
        else begin
          logic [7:0] e;
          e = q.pop_front();
          chk(rd_data_o == e, "R5 read data", rd_data_o, e);
          last_pop_cs_rise = cs_rise;
        end
      end
      rdv_prev = rd_valid_o;
    end
  end

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic send(input bit wr, input logic [14:0] a, input logic [7:0] d);
    if (wr) begin exp_mem[int'(a)] = d; n_wr++; end
    else q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready_o, "R8 busy after accept", req_ready_o, 0);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sram_cs_no && sram_we_no && sram_oe_no, "R1 strobes high in reset", {sram_cs_no, sram_we_no, sram_oe_no}, 7);
    chk(!sram_dq_oe_o && !rd_valid_o, "R1 driver off in reset", {sram_dq_oe_o, rd_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o, "R1 ready after reset", req_ready_o, 1);

    // R2 R3 R5: write then read back, various patterns
    send(1, 15'h0123, 8'hA5);
    send(0, 15'h0123, 8'h00);
    send(1, 15'h7FFF, 8'hFF);
    send(1, 15'h0000, 8'h00);
    send(1, 15'h2AAA, 8'h5A);      // R4: writes back to back
    send(0, 15'h7FFF, 8'h00);
    send(0, 15'h0000, 8'h00);
    send(0, 15'h1111, 8'h00);      // never written
    drain();

    // R6: chained reads keep cs low
    snap = cs_rise;
    send(0, 15'h2AAA, 8'h00);
    send(0, 15'h0123, 8'h00);
    send(0, 15'h7FFF, 8'h00);
    drain();
    chk(last_pop_cs_rise == snap, "R6 cs held across chained reads", last_pop_cs_rise - snap, 0);

    // R7: write queued behind a read, then verify
    send(0, 15'h0123, 8'h00);
    send(1, 15'h0123, 8'h3C);
    send(0, 15'h0123, 8'h00);
    send(1, 15'h5555, 8'hC3);
    send(1, 15'h5556, 8'h81);
    send(0, 15'h5555, 8'h00);
    send(0, 15'h5556, 8'h00);
    drain();

    // R1: asynchronous reset during a write pulse
    send(1, 15'h4444, 8'h99);
    @(negedge clk);
    rst_ni = 1'b0;
    #0.5;
    chk(sram_cs_no && sram_we_no && sram_oe_no && !sram_dq_oe_o, "R1 async reset mid-write",
        {sram_cs_no, sram_we_no, sram_oe_no, sram_dq_oe_o}, 14);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o, "R1 ready after abort", req_ready_o, 1);
    send(0, 15'h5556, 8'h00);
    drain();

    // R8: every write issued was performed exactly once (one aborted)
    chk(wr_count == n_wr - 1, "R8 write count", wr_count, n_wr - 1);
    chk(q.size() == 0, "R9 no outstanding reads", q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule